// File: doc/BRIEF.md
# Byte Processing Element with Pointer-Selected Instructions

This block is a single byte-wide processing element for a coarse-grained reconfigurable array. It keeps sixteen instructions in a local store. An external controller supplies a 4-bit pointer each cycle, and that pointer picks which stored instruction drives the element. Changing the pointer therefore changes the element's operation and operand routing from one cycle to the next, with no reload and no drain.

Each instruction picks one operation from a byte ALU (arithmetic, logic, compare, flag-driven select) or from a manipulation unit (shift, mask, constant, static byte choice, single-bit set, clear and test). It also says where each operand comes from: the 8-entry local register file, or straight from an input port. The result can go to the register file, to the output register, or to both. A 1-bit flag travels alongside the data. The incoming flag can serve as a carry-in or as a select, and the outgoing flag carries either the carry or the compare outcome.

The instruction store is filled through a plain write port while the element is stopped.

Top module: `bpe_cell`

## Requirements
- R1: An active-low reset clears the register file, the output byte and the output flag to zero. After reset, an instruction that reads registers sees zeros.
- R2: The instruction word is laid out as follows: [3:0] opcode, [4] A taken from in_a (else register), [5] B taken from in_b (else register), [8:6] A register, [11:9] B register, [14:12] destination register, [15] register write, [16] output write, [17] carry-in enable, [18] flag select (1 = compare, 0 = carry), [26:19] immediate. The instruction addressed by `ip` during a cycle sets the outputs that appear after that cycle's rising edge. A new pointer value takes effect on the very next cycle.
- R3: When `run` is 0, asserting `ld_we` stores `ld_data` at slot `ld_addr`. When `run` is 1, `ld_we` is ignored and the slot keeps its old instruction.
- R4: While `run` is 0, neither the register file, the output byte nor the output flag changes.
- R5: Operand A is `in_a` or register [8:6], and operand B is `in_b` or register [11:9], each chosen by its own bit. A register written at one edge is read with its new value in the next cycle.
- R6: The register write and the output write are independent. When the output write bit is 0, the output byte and the output flag hold their values.
- R7: Opcode 0 adds A + B, plus `flag_in` when carry-in is enabled, and its carry is the ninth bit. Opcode 1 computes A - B, and its carry is 1 when A >= B as unsigned values.
- R8: Opcodes 2, 3 and 4 are AND, OR and XOR. Opcode 5 yields A when `flag_in` is 1 and B otherwise.
- R9: Opcode 6 yields 1 when A == B and 0 otherwise. Opcode 7 yields 1 when A < B (unsigned) and 0 otherwise. In both cases the compare outcome is that same bit.
- R10: Opcode 8 shifts A left by B[2:0], filling with zeros. Opcode 9 shifts A right logically by B[2:0]. Opcode 10 yields A AND immediate. Opcode 11 yields the immediate.
- R11: Opcode 12 yields B when immediate bit 0 is 1 and A otherwise. Opcode 13 sets bit immediate[2:0] of A. Opcode 14 clears that bit. Opcode 15 yields that bit of A in bit 0 and uses it as the compare outcome.
- R12: On an output write, the flag output takes the compare outcome when the flag select bit is 1 and the carry when it is 0. The carry is 0 for opcodes other than 0 and 1, and the compare outcome is 0 for opcodes other than 6, 7 and 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Element executes when 1; loading allowed when 0 |
| ld_we | input | 1 | Instruction store write enable |
| ld_addr | input | 4 | Instruction store slot to write |
| ld_data | input | 27 | Instruction word to write |
| ip | input | 4 | Instruction pointer from the controller |
| in_a | input | 8 | First data input |
| in_b | input | 8 | Second data input |
| flag_in | input | 1 | Flag input (carry-in or select) |
| out_data | output | 8 | Registered result byte |
| flag_out | output | 1 | Registered flag |

## Verification
The bench switches the pointer on every cycle. A design that registered the pointer, or read the store one cycle late, would then show the result of the previous slot. Subtract operands are chosen on both sides of equality, so an inverted borrow sense appears as a wrong carry. Carry-in and select are run with both values of the incoming flag, which catches an ignored flag or swapped select arms. Stores attempted while running are followed by a read of that slot, which exposes a store that lets the write through. Cycles with `run` low are followed by reads of the output and of registers, which exposes a design that keeps executing while stopped.

// File: rtl/bpe_cell.sv
module bpe_cell #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int RFN   = 8,
  parameter int IW    = 10 + 3 * $clog2(RFN) + DW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     ld_we,
  input  logic [$clog2(DEPTH)-1:0] ld_addr,
  input  logic [IW-1:0]            ld_data,
  input  logic [$clog2(DEPTH)-1:0] ip,
  input  logic [DW-1:0]            in_a,
  input  logic [DW-1:0]            in_b,
  input  logic                     flag_in,
  output logic [DW-1:0]            out_data,
  output logic                     flag_out
);
  localparam int RW     = $clog2(RFN);
  localparam int SW     = $clog2(DW);
  localparam int F_ASEL = 4;
  localparam int F_BSEL = 5;
  localparam int F_RA   = 6;
  localparam int F_RB   = F_RA + RW;
  localparam int F_RD   = F_RB + RW;
  localparam int F_RFWE = F_RD + RW;
  localparam int F_OUTW = F_RFWE + 1;
  localparam int F_CIN  = F_OUTW + 1;
  localparam int F_FSEL = F_CIN + 1;
  localparam int F_IMM  = F_FSEL + 1;

  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR = 4'd3,
                         OP_XOR = 4'd4, OP_SEL = 4'd5, OP_EQ = 4'd6, OP_LTU = 4'd7,
                         OP_SHL = 4'd8, OP_SHR = 4'd9, OP_MSK = 4'd10, OP_CST = 4'd11,
                         OP_BSL = 4'd12, OP_BST = 4'd13, OP_BCL = 4'd14, OP_BTS = 4'd15;

  logic [IW-1:0] imem [DEPTH];
  logic [DW-1:0] rf   [RFN];

  always_ff @(posedge clk)
    if (ld_we && !run) imem[ld_addr] <= ld_data;

  logic [IW-1:0] ins;
  assign ins = imem[ip];

  logic [3:0]    op;
  logic          asel, bsel, rf_we, out_we, cin_en, fsel;
  logic [RW-1:0] ra, rb, rd;
  logic [DW-1:0] imm;
  assign op     = ins[3:0];
  assign asel   = ins[F_ASEL];
  assign bsel   = ins[F_BSEL];
  assign ra     = ins[F_RA +: RW];
  assign rb     = ins[F_RB +: RW];
  assign rd     = ins[F_RD +: RW];
  assign rf_we  = ins[F_RFWE];
  assign out_we = ins[F_OUTW];
  assign cin_en = ins[F_CIN];
  assign fsel   = ins[F_FSEL];
  assign imm    = ins[F_IMM +: DW];

  logic [DW-1:0] opa, opb;
  assign opa = asel ? in_a : rf[ra];
  assign opb = bsel ? in_b : rf[rb];

  logic [DW-1:0] bmask;
  assign bmask = DW'(1) << imm[SW-1:0];

  logic [DW-1:0] res;
  logic          carry, cmp;

  always_comb begin
    res   = '0;
    carry = 1'b0;
    cmp   = 1'b0;
    case (op)
      OP_ADD: {carry, res} = {1'b0, opa} + {1'b0, opb} + (DW+1)'(cin_en & flag_in);
      OP_SUB: {carry, res} = {1'b0, opa} + {1'b0, ~opb} + (DW+1)'(1);
      OP_AND: res = opa & opb;
      OP_OR:  res = opa | opb;
      OP_XOR: res = opa ^ opb;
      OP_SEL: res = flag_in ? opa : opb;
      OP_EQ: begin
        cmp = (opa == opb);
        res = {{(DW-1){1'b0}}, cmp};
      end
      OP_LTU: begin
        cmp = (opa < opb);
        res = {{(DW-1){1'b0}}, cmp};
      end
      OP_SHL: res = opa << opb[SW-1:0];
      OP_SHR: res = opa >> opb[SW-1:0];
      OP_MSK: res = opa & imm;
      OP_CST: res = imm;
      OP_BSL: res = imm[0] ? opb : opa;
      OP_BST: res = opa | bmask;
      OP_BCL: res = opa & ~bmask;
      OP_BTS: begin
        cmp = |(opa & bmask);
        res = {{(DW-1){1'b0}}, cmp};
      end
      default: res = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RFN; i++) rf[i] <= '0;
    end else if (run && rf_we) begin
      rf[rd] <= res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      flag_out <= 1'b0;
    end else if (run && out_we) begin
      out_data <= res;
      flag_out <= fsel ? cmp : carry;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (out_data == '0 && !flag_out));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(out_data) && $stable(flag_out)));

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !out_we) |=> ($stable(out_data) && $stable(flag_out)));

  assert_const_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && out_we && op == OP_CST) |=> (out_data == $past(imm)));

  assert_eq_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && out_we && fsel && op == OP_EQ) |=> (flag_out == ($past(opa) == $past(opb))));

  assert_no_carry_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (run && out_we && !fsel && op[3]) |=> !flag_out);
endmodule

// File: tb/bpe_cell_tb.sv
`timescale 1ns/1ps
module bpe_cell_tb;
  localparam int IW = 27;

  logic          clk = 1'b0, rst_n = 1'b0, run = 1'b0, ld_we = 1'b0, flag_in = 1'b0;
  logic [3:0]    ld_addr = '0, ip = '0;
  logic [IW-1:0] ld_data = '0;
  logic [7:0]    in_a = '0, in_b = '0;
  wire  [7:0]    out_data;
  wire           flag_out;

  bpe_cell u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .ip(ip), .in_a(in_a), .in_b(in_b), .flag_in(flag_in),
    .out_data(out_data), .flag_out(flag_out)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [7:0] d;
    logic       f;
    string      tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0]    m_rf [8];
  logic [IW-1:0] m_imem [16];
  logic [7:0]    m_out = '0;
  logic          m_f = 1'b0;

  function automatic logic [IW-1:0] enc(input logic [3:0] op, input logic as, input logic bs,
      input logic [2:0] ra, input logic [2:0] rb, input logic [2:0] rd, input logic rwe,
      input logic owe, input logic cin, input logic fs, input logic [7:0] imm);
    return {imm, fs, cin, owe, rwe, rd, rb, ra, bs, as, op};
  endfunction

  task automatic model_exec(input logic [IW-1:0] w, input logic [7:0] a_in,
                            input logic [7:0] b_in, input logic fi);
    logic [7:0] a, b, r, bm;
    logic [8:0] s;
    logic c, k;
    a = w[4] ? a_in : m_rf[w[8:6]];
    b = w[5] ? b_in : m_rf[w[11:9]];
    bm = 8'd1 << w[21:19];
    r = 0; c = 0; k = 0;
    case (w[3:0])
      4'd0: begin s = a + b + (w[17] & fi); r = s[7:0]; c = s[8]; end
      4'd1: begin r = a - b; c = (a >= b); end
      4'd2: r = a & b;
      4'd3: r = a | b;
      4'd4: r = a ^ b;
      4'd5: r = fi ? a : b;
      4'd6: begin k = (a == b); r = {7'd0, k}; end
      4'd7: begin k = (a < b); r = {7'd0, k}; end
      4'd8: r = a << b[2:0];
      4'd9: r = a >> b[2:0];
      4'd10: r = a & w[26:19];
      4'd11: r = w[26:19];
      4'd12: r = w[19] ? b : a;
      4'd13: r = a | bm;
      4'd14: r = a & ~bm;
      default: begin k = ((a & bm) != 0); r = {7'd0, k}; end
    endcase
    if (w[15]) m_rf[w[14:12]] = r;
    if (w[16]) begin m_out = r; m_f = w[18] ? k : c; end
  endtask

  task automatic cyc(input logic r, input logic [3:0] p, input logic [7:0] a, input logic [7:0] b,
                     input logic fi, input logic we, input logic [3:0] la,
                     input logic [IW-1:0] ld, input string tag);
    exp_t e;
    @(negedge clk);
    run = r; ip = p; in_a = a; in_b = b; flag_in = fi;
    ld_we = we; ld_addr = la; ld_data = ld;
    if (r) model_exec(m_imem[p], a, b, fi);
    if (we && !r) m_imem[la] = ld;
    @(posedge clk);
    #1;
    ld_we = 1'b0;
    e.d = m_out; e.f = m_f; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic ex(input logic [3:0] p, input logic [7:0] a, input logic [7:0] b,
                    input logic fi, input string tag);
    cyc(1'b1, p, a, b, fi, 1'b0, 4'd0, '0, tag);
  endtask

  task automatic chk(input logic [7:0] gd, input logic gf, input logic [7:0] ed,
                     input logic ef, input string tag);
    checks++;
    if (gd !== ed || gf !== ef) begin
      errors++;
      $display("FAIL %s: out=%02h flag=%0b expected out=%02h flag=%0b", tag, gd, gf, ed, ef);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(out_data, flag_out, e.d, e.f, e.tag);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic string tag_of(input logic [3:0] s);
    if (s < 2) return "R7";
    if (s < 6) return "R8";
    if (s < 8) return "R9";
    if (s < 12) return "R10";
    return "R11";
  endfunction

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [IW-1:0] prog [16];
    for (int i = 0; i < 8; i++) m_rf[i] = '0;
    prog[0]  = enc(4'd0, 1, 1, 0, 0, 1, 1, 1, 1, 0, 8'h00);
    prog[1]  = enc(4'd1, 0, 1, 1, 0, 0, 0, 1, 0, 0, 8'h00);
    prog[2]  = enc(4'd2, 1, 1, 0, 0, 2, 1, 1, 0, 0, 8'h00);
    prog[3]  = enc(4'd3, 0, 1, 2, 0, 0, 0, 1, 0, 0, 8'h00);
    prog[4]  = enc(4'd4, 1, 1, 0, 0, 3, 1, 1, 0, 0, 8'h00);
    prog[5]  = enc(4'd5, 1, 1, 0, 0, 0, 0, 1, 0, 0, 8'h00);
    prog[6]  = enc(4'd6, 1, 1, 0, 0, 0, 0, 1, 0, 1, 8'h00);
    prog[7]  = enc(4'd7, 1, 0, 0, 3, 0, 0, 1, 0, 1, 8'h00);
    prog[8]  = enc(4'd8, 1, 1, 0, 0, 4, 1, 1, 0, 0, 8'h00);
    prog[9]  = enc(4'd9, 0, 1, 4, 0, 0, 0, 1, 0, 0, 8'h00);
    prog[10] = enc(4'd10, 1, 1, 0, 0, 0, 0, 1, 0, 0, 8'h0F);
    prog[11] = enc(4'd11, 1, 1, 0, 0, 5, 1, 0, 0, 0, 8'hA5);
    prog[12] = enc(4'd12, 0, 1, 5, 0, 0, 0, 1, 0, 0, 8'h01);
    prog[13] = enc(4'd13, 0, 1, 5, 0, 6, 1, 1, 0, 0, 8'h01);
    prog[14] = enc(4'd14, 1, 1, 0, 0, 0, 0, 1, 0, 0, 8'h07);
    prog[15] = enc(4'd15, 0, 1, 6, 0, 0, 0, 1, 0, 1, 8'h01);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_data, flag_out, 8'h00, 1'b0, "R1");
    rst_n = 1'b1;

    for (int i = 0; i < 16; i++) cyc(1'b0, 4'd0, 8'hFF, 8'hFF, 1'b1, 1'b1, 4'(i), prog[i], "R3");

    ex(4'd1, 8'h00, 8'h00, 1'b0, "R1");
    ex(4'd0, 8'hF0, 8'h20, 1'b1, "R7");
    ex(4'd0, 8'h01, 8'h02, 1'b0, "R7");
    ex(4'd1, 8'h00, 8'h05, 1'b0, "R5");
    ex(4'd1, 8'h00, 8'h03, 1'b0, "R7");
    ex(4'd2, 8'hCC, 8'hAA, 1'b0, "R8");
    ex(4'd3, 8'h00, 8'h01, 1'b0, "R8");
    ex(4'd4, 8'hF0, 8'h3C, 1'b0, "R8");
    ex(4'd5, 8'h11, 8'h22, 1'b1, "R8");
    ex(4'd5, 8'h11, 8'h22, 1'b0, "R8");
    ex(4'd6, 8'h5A, 8'h5A, 1'b0, "R12");
    ex(4'd6, 8'h5A, 8'h5B, 1'b0, "R9");
    ex(4'd7, 8'h10, 8'h00, 1'b0, "R9");
    ex(4'd7, 8'hFF, 8'h00, 1'b0, "R9");
    ex(4'd8, 8'h81, 8'h03, 1'b0, "R10");
    ex(4'd9, 8'h00, 8'h02, 1'b0, "R10");
    ex(4'd10, 8'h7E, 8'h00, 1'b0, "R10");
    ex(4'd11, 8'h00, 8'h00, 1'b0, "R6");
    ex(4'd12, 8'h00, 8'h3D, 1'b0, "R11");
    ex(4'd13, 8'h00, 8'h00, 1'b0, "R11");
    ex(4'd15, 8'h00, 8'h00, 1'b0, "R11");
    ex(4'd14, 8'hFF, 8'h00, 1'b0, "R11");
    ex(4'd0, 8'hFF, 8'h01, 1'b0, "R12");
    ex(4'd8, 8'h01, 8'h0A, 1'b0, "R12");

    cyc(1'b0, 4'd2, 8'h00, 8'h00, 1'b0, 1'b0, 4'd0, '0, "R4");
    cyc(1'b0, 4'd4, 8'h77, 8'h00, 1'b0, 1'b0, 4'd0, '0, "R4");
    ex(4'd7, 8'h00, 8'h00, 1'b0, "R4");
    ex(4'd3, 8'h00, 8'h00, 1'b0, "R4");

    cyc(1'b1, 4'd6, 8'h01, 8'h01, 1'b0, 1'b1, 4'd0,
        enc(4'd11, 1, 1, 0, 0, 0, 0, 1, 0, 0, 8'h3C), "R3");
    ex(4'd0, 8'h10, 8'h20, 1'b0, "R3");
    cyc(1'b0, 4'd0, 8'h00, 8'h00, 1'b0, 1'b1, 4'd0,
        enc(4'd11, 1, 1, 0, 0, 0, 0, 1, 0, 0, 8'h3C), "R3");
    ex(4'd0, 8'h10, 8'h20, 1'b0, "R3");
    cyc(1'b0, 4'd0, 8'h00, 8'h00, 1'b0, 1'b1, 4'd0, prog[0], "R3");
    ex(4'd0, 8'h10, 8'h20, 1'b0, "R2");
    ex(4'd10, 8'hF3, 8'h00, 1'b0, "R2");

    for (int i = 0; i < 400; i++) begin
      automatic logic [3:0] s = 4'($urandom);
      automatic logic r = ($urandom % 8) != 0;
      automatic logic [7:0] a = 8'($urandom);
      automatic logic [7:0] b = 8'($urandom);
      automatic logic fi = 1'($urandom);
      cyc(r, s, a, b, fi, 1'b0, 4'd0, '0, r ? tag_of(s) : "R4");
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule